// File: doc/BRIEF.md
# Multi-Thread Squash and Trap Sequencer

This block is the control part of the retire stage of an out-of-order core that runs up to four hardware threads. Each thread has its own state machine. Every cycle, the state machine decides whether its thread starts a pipeline flush. A flush can have one of three causes. The first is a trap that was accepted earlier and has waited out a programmable latency. The second is a context-change request from outside. The third is a redirect reported back by the execute stage.

When a flush starts, the block broadcasts the following to the front of the pipe:
- a restart sequence number,
- a one-cycle squash strobe,
- a level that stays high while the flush is in progress,
- a mispredict flag and a taken flag,
- a redirect PC and the PC of the offending instruction.

The reorder buffer, fetch and trap handling stay outside the block. They are seen only through the head sequence number, the empty flag, the flush-finished flag and the saved PC of each thread.

Execute-stage redirects pass through an age filter. A redirect is taken only if it is not younger than the youngest instruction still valid for the thread. This stops a late report about a younger instruction from overriding an older flush that has already started.

Top module: `squash_ctrl`

## Requirements
- R1: Reset is synchronous and active low. After reset, every thread reads state 0 (idle), and the squash, busy and error outputs are low. The mispredict count is zero and each thread's youngest-valid number is all ones.
- R2: An idle thread (state 0) moves to running (state 1) on the edge where its enable input is high.
- R3: A trap accept moves the thread to state 3, or to state 4 when the fetch-fault qualifier is set. It also loads the latency L (L=0 acts as 1). The trap-squash flag is set L edges after the accept edge. The squash broadcast follows on the next edge.
- R4: A context-change request is held as pending on the edge where it is seen. The squash broadcast follows on the next edge.
- R5: A trap or context squash drives these values:
  - restart number: head sequence number minus one, or 0 when the buffer is empty;
  - youngest-valid number: set to 0;
  - mispredict and taken: cleared;
  - mispredicting PC: 0;
  - redirect PC: the thread's saved PC.
- R6: A trap squash wins over a context squash. When both are pending in the same cycle, one squash is broadcast with the error strobe set. Both causes are then cleared, so no second squash follows.
- R7: An execute-stage squash is accepted only when both of these hold:
  - the thread is not in state 3;
  - its sequence number is at or below the youngest-valid number.
  
  The restart number is the reported number, minus one when the include flag is set. The youngest-valid number takes the restart value. The mispredict flag, taken flag, redirect PC and mispredicting PC are forwarded unchanged. The broadcast appears one edge after the request.
- R8: When a trap or context squash starts in the same cycle as an execute-stage squash, only the full squash is broadcast. The execute-stage fields are dropped and the mispredict count does not move.
- R9: A squash puts the thread in state 2. The busy output is high for as long as the thread is in state 2. The thread returns to state 1 on the edge where the buffer reports the flush finished.
- R10: The mispredict count rises by the number of threads that had an execute-stage squash accepted in that cycle with the mispredict flag set.
- R11: A rejected execute-stage squash produces no strobe. It leaves the thread state, the youngest-valid number and the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_en | input | NT | Per-thread enable, moves an idle thread to running |
| trap_accept | input | NT | Per-thread trap accepted |
| trap_fetch | input | NT | Qualifies trap_accept as a fetch-side fault |
| trap_latency | input | LW | Cycles from trap accept to trap-squash flag |
| ctx_req | input | NT | Per-thread context-change squash request |
| exe_squash | input | NT | Execute-stage squash request per thread |
| exe_seq | input | NT*SW | Reported sequence number per thread |
| exe_incl | input | NT | Include the offending instruction in the squash |
| exe_mispred | input | NT | Report is a branch mispredict |
| exe_taken | input | NT | Branch direction for the report |
| exe_npc | input | NT*PW | Redirect PC from execute |
| exe_mpc | input | NT*PW | Mispredicting PC from execute |
| rob_head_seq | input | NT*SW | Head entry sequence number per thread |
| rob_empty | input | NT | Reorder buffer empty for the thread |
| rob_sq_done | input | NT | Reorder buffer finished flushing the thread |
| saved_pc | input | NT*PW | Saved restart PC per thread |
| thr_state | output | NT*3 | Thread state code (0 idle, 1 running, 2 squashing, 3 trap wait, 4 fetch-trap wait) |
| bc_squash | output | NT | One-cycle squash strobe |
| bc_busy | output | NT | Flush in progress |
| bc_seq | output | NT*SW | Restart sequence number |
| bc_mispred | output | NT | Mispredict flag of the last squash |
| bc_taken | output | NT | Taken flag of the last squash |
| bc_npc | output | NT*PW | Redirect PC of the last squash |
| bc_mpc | output | NT*PW | Mispredicting PC of the last squash |
| yng_seq | output | NT*SW | Youngest-valid sequence number per thread |
| conflict_err | output | NT | Trap and context squash were both pending |
| mispred_cnt | output | CW | Accepted mispredict squashes |

## Verification
The age filter gets the closest attention. The bench sweeps reports at exactly the youngest-valid number, one above it and several below it, with and without the include flag. An off-by-one comparison would accept a younger report or reject an equal one. A wrong restart value would then show up in the next filter decision.

Trap latency is swept from 0 to 4 on every thread, with a check on the cycle just before the strobe. A counter that is one short or one long would fire early or late. Treating L=0 as "no wait" would break the first case.

The bench also checks three conflict cases:
- a context squash that lands on top of an execute redirect must not leak the mispredict flag or bump the count;
- an execute redirect during trap wait must be ignored;
- a trap and a context squash pending together must produce exactly one squash with the error strobe.

// File: rtl/sqc_pkg.sv
// Shared types for the squash sequencer.
// Assumes state codes are observed outside the block, so values are fixed.
package sqc_pkg;
    typedef enum logic [2:0] {
        TS_IDLE   = 3'd0,
        TS_RUN    = 3'd1,
        TS_SQUASH = 3'd2,
        TS_TRAP   = 3'd3,
        TS_FTRAP  = 3'd4
    } thr_state_e;
endpackage

// File: rtl/sqc_trap_timer.sv
// Per-thread trap latency timer.
// Loads a latency on accept and raises a sticky flag that many edges later
// (zero is treated as one). The flag drops when the owner consumes it.
module sqc_trap_timer #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LAT_W-1:0] lat,
    input  logic             consume,
    output logic             fire
);
    logic [LAT_W-1:0] cnt;
    logic             run;

    // Count down after a load and set the flag on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            run  <= 1'b0;
            fire <= 1'b0;
        end else begin
            if (consume) fire <= 1'b0;
            if (load) begin
                run <= 1'b1;
                cnt <= (lat == '0) ? LAT_W'(1) : lat;
            end else if (run) begin
                if (cnt <= LAT_W'(1)) begin
                    run  <= 1'b0;
                    fire <= 1'b1;
                end else begin
                    cnt <= cnt - LAT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/sqc_thread.sv
// One thread's squash decision, state machine and broadcast registers.
// Assumes the caller provides the reorder buffer head, empty and done flags
// for this thread; sequence numbers compare as unsigned (smaller is older).
module sqc_thread
    import sqc_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32,
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_en,
    input  logic             trap_accept,
    input  logic             trap_fetch,
    input  logic [LAT_W-1:0] trap_latency,
    input  logic             ctx_req,
    input  logic             exe_squash,
    input  logic [SEQ_W-1:0] exe_seq,
    input  logic             exe_incl,
    input  logic             exe_mispred,
    input  logic             exe_taken,
    input  logic [PC_W-1:0]  exe_npc,
    input  logic [PC_W-1:0]  exe_mpc,
    input  logic [SEQ_W-1:0] rob_head_seq,
    input  logic             rob_empty,
    input  logic             rob_sq_done,
    input  logic [PC_W-1:0]  saved_pc,
    output logic [2:0]       state_o,
    output logic             bc_squash,
    output logic             bc_busy,
    output logic [SEQ_W-1:0] bc_seq,
    output logic             bc_mispred,
    output logic             bc_taken,
    output logic [PC_W-1:0]  bc_npc,
    output logic [PC_W-1:0]  bc_mpc,
    output logic [SEQ_W-1:0] yng_seq,
    output logic             conflict_err,
    output logic             mis_inc
);
    thr_state_e       state, state_nx;
    logic             trap_fire;
    logic             ctx_pend;
    logic             full_go, exe_ok, exe_go;
    logic [SEQ_W-1:0] full_seq, exe_rst;

    sqc_trap_timer #(.LAT_W(LAT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (trap_accept),
        .lat     (trap_latency),
        .consume (full_go),
        .fire    (trap_fire)
    );

    // Pick the squash source for this cycle with fixed priority.
    always_comb begin
        full_go  = trap_fire | ctx_pend;
        exe_ok   = exe_squash && (state != TS_TRAP) && (exe_seq <= yng_seq);
        exe_go   = exe_ok && !full_go;
        full_seq = rob_empty ? '0 : rob_head_seq - SEQ_W'(1);
        exe_rst  = exe_incl ? exe_seq - SEQ_W'(1) : exe_seq;
        mis_inc  = exe_go & exe_mispred;
    end

    // Next thread state.
    always_comb begin
        state_nx = state;
        if (full_go || exe_go) begin
            state_nx = TS_SQUASH;
        end else if (trap_accept) begin
            state_nx = trap_fetch ? TS_FTRAP : TS_TRAP;
        end else begin
            case (state)
                TS_IDLE:   if (thr_en)      state_nx = TS_RUN;
                TS_SQUASH: if (rob_sq_done) state_nx = TS_RUN;
                default:   state_nx = state;
            endcase
        end
    end

    // State, pending context request and squash broadcast registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= TS_IDLE;
            ctx_pend     <= 1'b0;
            bc_squash    <= 1'b0;
            conflict_err <= 1'b0;
            bc_seq       <= '0;
            bc_mispred   <= 1'b0;
            bc_taken     <= 1'b0;
            bc_npc       <= '0;
            bc_mpc       <= '0;
            yng_seq      <= '1;
        end else begin
            state        <= state_nx;
            ctx_pend     <= ctx_req | (ctx_pend & ~full_go);
            bc_squash    <= full_go | exe_go;
            conflict_err <= trap_fire & ctx_pend;
            if (full_go) begin
                bc_seq     <= full_seq;
                yng_seq    <= '0;
                bc_mispred <= 1'b0;
                bc_taken   <= 1'b0;
                bc_npc     <= saved_pc;
                bc_mpc     <= '0;
            end else if (exe_go) begin
                bc_seq     <= exe_rst;
                yng_seq    <= exe_rst;
                bc_mispred <= exe_mispred;
                bc_taken   <= exe_taken;
                bc_npc     <= exe_npc;
                bc_mpc     <= exe_mpc;
            end
        end
    end

    assign state_o = state;
    assign bc_busy = (state == TS_SQUASH);
endmodule

// File: rtl/sqc_event_counter.sv
// Adds the number of set bits of a per-thread strobe vector each cycle.
// Assumes wrap-around is acceptable for a plain event count.
module sqc_event_counter #(
    parameter int N = 4,
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] inc,
    output logic [W-1:0] count
);
    logic [W-1:0] add;

    // Population count of the strobes.
    always_comb begin
        add = '0;
        for (int i = 0; i < N; i++) add = add + W'(inc[i]);
    end

    // Accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + add;
    end
endmodule

// File: rtl/squash_ctrl.sv
// Top of the multi-thread squash and trap sequencer.
// Replicates one controller per thread and sums accepted mispredicts.
// Assumes all per-thread buses are packed thread 0 in the low slice.
module squash_ctrl #(
    parameter int NT = 4,
    parameter int SW = 16,
    parameter int PW = 32,
    parameter int LW = 8,
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NT-1:0]    thr_en,
    input  logic [NT-1:0]    trap_accept,
    input  logic [NT-1:0]    trap_fetch,
    input  logic [LW-1:0]    trap_latency,
    input  logic [NT-1:0]    ctx_req,
    input  logic [NT-1:0]    exe_squash,
    input  logic [NT*SW-1:0] exe_seq,
    input  logic [NT-1:0]    exe_incl,
    input  logic [NT-1:0]    exe_mispred,
    input  logic [NT-1:0]    exe_taken,
    input  logic [NT*PW-1:0] exe_npc,
    input  logic [NT*PW-1:0] exe_mpc,
    input  logic [NT*SW-1:0] rob_head_seq,
    input  logic [NT-1:0]    rob_empty,
    input  logic [NT-1:0]    rob_sq_done,
    input  logic [NT*PW-1:0] saved_pc,
    output logic [NT*3-1:0]  thr_state,
    output logic [NT-1:0]    bc_squash,
    output logic [NT-1:0]    bc_busy,
    output logic [NT*SW-1:0] bc_seq,
    output logic [NT-1:0]    bc_mispred,
    output logic [NT-1:0]    bc_taken,
    output logic [NT*PW-1:0] bc_npc,
    output logic [NT*PW-1:0] bc_mpc,
    output logic [NT*SW-1:0] yng_seq,
    output logic [NT-1:0]    conflict_err,
    output logic [CW-1:0]    mispred_cnt
);
    localparam int ST_W = 3;

    logic [NT-1:0] mis_inc;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        sqc_thread #(.SEQ_W(SW), .PC_W(PW), .LAT_W(LW)) u_thr (
            .clk          (clk),
            .rst_n        (rst_n),
            .thr_en       (thr_en[t]),
            .trap_accept  (trap_accept[t]),
            .trap_fetch   (trap_fetch[t]),
            .trap_latency (trap_latency),
            .ctx_req      (ctx_req[t]),
            .exe_squash   (exe_squash[t]),
            .exe_seq      (exe_seq[t*SW +: SW]),
            .exe_incl     (exe_incl[t]),
            .exe_mispred  (exe_mispred[t]),
            .exe_taken    (exe_taken[t]),
            .exe_npc      (exe_npc[t*PW +: PW]),
            .exe_mpc      (exe_mpc[t*PW +: PW]),
            .rob_head_seq (rob_head_seq[t*SW +: SW]),
            .rob_empty    (rob_empty[t]),
            .rob_sq_done  (rob_sq_done[t]),
            .saved_pc     (saved_pc[t*PW +: PW]),
            .state_o      (thr_state[t*ST_W +: ST_W]),
            .bc_squash    (bc_squash[t]),
            .bc_busy      (bc_busy[t]),
            .bc_seq       (bc_seq[t*SW +: SW]),
            .bc_mispred   (bc_mispred[t]),
            .bc_taken     (bc_taken[t]),
            .bc_npc       (bc_npc[t*PW +: PW]),
            .bc_mpc       (bc_mpc[t*PW +: PW]),
            .yng_seq      (yng_seq[t*SW +: SW]),
            .conflict_err (conflict_err[t]),
            .mis_inc      (mis_inc[t])
        );
    end

    sqc_event_counter #(.N(NT), .W(CW)) u_miscnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (mis_inc),
        .count (mispred_cnt)
    );
endmodule

// File: rtl/sqc_checker.sv
// Temporal checks on the sequencer's ports, attached by bind.
module sqc_checker #(
    parameter int NT = 4,
    parameter int SW = 16,
    parameter int PW = 32,
    parameter int CW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NT-1:0]    trap_accept,
    input logic [NT-1:0]    exe_squash,
    input logic [NT-1:0]    exe_mispred,
    input logic [NT-1:0]    rob_sq_done,
    input logic [NT*PW-1:0] saved_pc,
    input logic [NT*3-1:0]  thr_state,
    input logic [NT-1:0]    bc_squash,
    input logic [NT-1:0]    bc_busy,
    input logic [NT-1:0]    bc_mispred,
    input logic [NT*PW-1:0] bc_npc,
    input logic [NT-1:0]    conflict_err,
    input logic [CW-1:0]    mispred_cnt
);
    for (genvar t = 0; t < NT; t++) begin : g_chk
        AST_SQUASH_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            bc_squash[t] |-> bc_busy[t]); // R9
        AST_BUSY_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(bc_busy[t]) |-> $past(rob_sq_done[t] | trap_accept[t])); // R9
        AST_TRAP_STATE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            (bc_squash[t] && $past(thr_state[t*3 +: 3]) == 3'd3)
            |-> (!bc_mispred[t] && bc_npc[t*PW +: PW] == $past(saved_pc[t*PW +: PW]))); // R7
        AST_CONFLICT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            conflict_err[t] |-> (bc_squash[t] && !bc_mispred[t])); // R6
        AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            thr_state[t*3 +: 3] <= 3'd4); // R1
    end

    AST_COUNT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (mispred_cnt != $past(mispred_cnt)) |-> $past(|(exe_squash & exe_mispred))); // R10
endmodule

bind squash_ctrl sqc_checker #(.NT(NT), .SW(SW), .PW(PW), .CW(CW)) u_sqc_checker (.*);

// File: tb/sim_squash_ctrl.sv
module sim_squash_ctrl;
    localparam int CLK_P = 10;
    localparam int NT = 4, SW = 16, PW = 32, LW = 8, CW = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic [NT-1:0]    thr_en, trap_accept, trap_fetch, ctx_req, exe_squash;
    logic [NT-1:0]    exe_incl, exe_mispred, exe_taken, rob_empty, rob_sq_done;
    logic [LW-1:0]    trap_latency;
    logic [NT*SW-1:0] exe_seq, rob_head_seq;
    logic [NT*PW-1:0] exe_npc, exe_mpc, saved_pc;
    logic [NT*3-1:0]  thr_state;
    logic [NT-1:0]    bc_squash, bc_busy, bc_mispred, bc_taken, conflict_err;
    logic [NT*SW-1:0] bc_seq, yng_seq;
    logic [NT*PW-1:0] bc_npc, bc_mpc;
    logic [CW-1:0]    mispred_cnt;

    int total = 0;
    int bad = 0;
    int model_yng [NT];
    int mcnt = 0;

    always #(CLK_P/2) clk = ~clk;

    squash_ctrl #(.NT(NT), .SW(SW), .PW(PW), .LW(LW), .CW(CW)) u0 (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [2:0] st(input int t);
        return thr_state[t*3 +: 3];
    endfunction

    task automatic drive_exe(input int t, input int seq, input bit incl, input bit mis,
                             input bit tkn, input int npc, input int mpc);
        exe_squash[t]         = 1'b1;
        exe_seq[t*SW +: SW]   = SW'(seq);
        exe_incl[t]           = incl;
        exe_mispred[t]        = mis;
        exe_taken[t]          = tkn;
        exe_npc[t*PW +: PW]   = PW'(npc);
        exe_mpc[t*PW +: PW]   = PW'(mpc);
    endtask

    task automatic finish_squash(input int t);
        rob_sq_done[t] = 1'b1;
        step();
        rob_sq_done[t] = 1'b0;
        chk("R9 back to running", 64'(st(t)), 64'd1);
        chk("R9 busy low", 64'(bc_busy[t]), 64'd0);
    endtask

    initial begin
        rst_n = 1'b0;
        thr_en = '0; trap_accept = '0; trap_fetch = '0; ctx_req = '0; exe_squash = '0;
        exe_incl = '0; exe_mispred = '0; exe_taken = '0; rob_empty = '0; rob_sq_done = '0;
        trap_latency = '0; exe_seq = '0; rob_head_seq = '0; exe_npc = '0; exe_mpc = '0;
        for (int t = 0; t < NT; t++) saved_pc[t*PW +: PW] = PW'(32'h1000 + t * 32'h100);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 state", 64'(thr_state), 64'd0);
        chk("R1 squash", 64'(bc_squash), 64'd0);
        chk("R1 busy", 64'(bc_busy), 64'd0);
        chk("R1 err", 64'(conflict_err), 64'd0);
        chk("R1 count", 64'(mispred_cnt), 64'd0);
        for (int t = 0; t < NT; t++) begin
            chk("R1 youngest", 64'(yng_seq[t*SW +: SW]), 64'hFFFF);
            model_yng[t] = 32'hFFFF;
        end

        // R2 idle to running
        thr_en = '1;
        step();
        for (int t = 0; t < NT; t++) chk("R2 running", 64'(st(t)), 64'd1);

        // R7 / R11 / R10 age filter sweep
        for (int t = 0; t < NT; t++) begin
            for (int k = 0; k < 10; k++) begin
                int seq, rst;
                bit incl, mis, tkn, acc;
                if (k % 2 == 1)      seq = model_yng[t] + 1;
                else if (k % 4 == 2) seq = model_yng[t];
                else                 seq = model_yng[t] - 3 - k - t;
                incl = (k % 3 == 0);
                mis  = ((k + t) % 2 == 1);
                tkn  = (k % 3 == 1);
                acc  = (seq <= model_yng[t]);
                rst  = incl ? seq - 1 : seq;
                drive_exe(t, seq, incl, mis, tkn, 32'h4000 + k * 16 + t, 32'h8000 + k + t * 256);
                step();
                exe_squash = '0;
                chk("R7 accept decision", 64'(bc_squash[t]), 64'(acc));
                if (acc) begin
                    mcnt += mis;
                    model_yng[t] = rst;
                    chk("R7 restart seq", 64'(bc_seq[t*SW +: SW]), 64'(rst));
                    chk("R7 youngest", 64'(yng_seq[t*SW +: SW]), 64'(rst));
                    chk("R7 mispred", 64'(bc_mispred[t]), 64'(mis));
                    chk("R7 taken", 64'(bc_taken[t]), 64'(tkn));
                    chk("R7 npc", 64'(bc_npc[t*PW +: PW]), 64'(32'h4000 + k * 16 + t));
                    chk("R7 mpc", 64'(bc_mpc[t*PW +: PW]), 64'(32'h8000 + k + t * 256));
                    chk("R9 squashing state", 64'(st(t)), 64'd2);
                    chk("R9 busy", 64'(bc_busy[t]), 64'd1);
                    chk("R10 count", 64'(mispred_cnt), 64'(mcnt));
                    finish_squash(t);
                end else begin
                    chk("R11 state kept", 64'(st(t)), 64'd1);
                    chk("R11 youngest kept", 64'(yng_seq[t*SW +: SW]), 64'(model_yng[t]));
                    chk("R11 count kept", 64'(mispred_cnt), 64'(mcnt));
                end
            end
        end

        // R10 all threads in one cycle
        for (int t = 0; t < NT; t++) drive_exe(t, model_yng[t], 1'b0, 1'b1, 1'b0, 32'h5000, 32'h6000);
        step();
        exe_squash = '0;
        mcnt += NT;
        chk("R10 multi count", 64'(mispred_cnt), 64'(mcnt));
        chk("R10 multi strobes", 64'(bc_squash), 64'hF);
        rob_sq_done = '1;
        step();
        rob_sq_done = '0;

        // R3 / R5 trap latency sweep
        for (int t = 0; t < NT; t++) begin
            for (int L = 0; L < 5; L++) begin
                bit fetch;
                int head, eff;
                fetch = (L % 2 == 0);
                head  = 100 + t * 10 + L;
                eff   = (L == 0) ? 1 : L;
                rob_empty[t] = (L == 3);
                rob_head_seq[t*SW +: SW] = SW'(head);
                trap_accept[t] = 1'b1;
                trap_fetch[t]  = fetch;
                trap_latency   = LW'(L);
                step();
                trap_accept = '0;
                trap_fetch  = '0;
                chk("R3 trap state", 64'(st(t)), fetch ? 64'd4 : 64'd3);
                if (!fetch) drive_exe(t, 0, 1'b0, 1'b1, 1'b0, 32'h7000, 32'h7004);
                for (int i = 0; i < eff; i++) begin
                    step();
                    exe_squash = '0;
                    chk("R3 no early squash", 64'(bc_squash[t]), 64'd0);
                end
                step();
                chk("R3 squash on time", 64'(bc_squash[t]), 64'd1);
                chk("R5 state", 64'(st(t)), 64'd2);
                chk("R5 restart seq", 64'(bc_seq[t*SW +: SW]), (L == 3) ? 64'd0 : 64'(head - 1));
                chk("R5 youngest zero", 64'(yng_seq[t*SW +: SW]), 64'd0);
                chk("R5 mispred clear", 64'(bc_mispred[t]), 64'd0);
                chk("R5 taken clear", 64'(bc_taken[t]), 64'd0);
                chk("R5 mpc zero", 64'(bc_mpc[t*PW +: PW]), 64'd0);
                chk("R5 saved pc", 64'(bc_npc[t*PW +: PW]), 64'(32'h1000 + t * 32'h100));
                chk("R7 trap wait ignores exe", 64'(mispred_cnt), 64'(mcnt));
                finish_squash(t);
                rob_empty[t] = 1'b0;
            end
        end

        // R4 / R8 context squash over an execute redirect
        rob_head_seq[2*SW +: SW] = SW'(55);
        ctx_req[2] = 1'b1;
        step();
        ctx_req = '0;
        chk("R4 pending only", 64'(bc_squash[2]), 64'd0);
        chk("R4 still running", 64'(st(2)), 64'd1);
        drive_exe(2, 0, 1'b0, 1'b1, 1'b1, 32'h9999, 32'h9990);
        step();
        exe_squash = '0;
        chk("R4 squash", 64'(bc_squash[2]), 64'd1);
        chk("R8 mispred dropped", 64'(bc_mispred[2]), 64'd0);
        chk("R8 pc from saved", 64'(bc_npc[2*PW +: PW]), 64'h1200);
        chk("R8 count kept", 64'(mispred_cnt), 64'(mcnt));
        chk("R5 ctx restart", 64'(bc_seq[2*SW +: SW]), 64'd54);
        finish_squash(2);

        // R6 trap and context both pending
        trap_accept[1] = 1'b1;
        trap_latency   = LW'(2);
        step();
        trap_accept = '0;
        step();
        ctx_req[1] = 1'b1;
        step();
        ctx_req = '0;
        chk("R6 not yet", 64'(bc_squash[1]), 64'd0);
        step();
        chk("R6 squash", 64'(bc_squash[1]), 64'd1);
        chk("R6 error strobe", 64'(conflict_err[1]), 64'd1);
        chk("R6 trap wins", 64'(bc_mispred[1]), 64'd0);
        step();
        chk("R6 single squash", 64'(bc_squash[1]), 64'd0);
        chk("R6 error clears", 64'(conflict_err[1]), 64'd0);
        chk("R6 still squashing", 64'(st(1)), 64'd2);
        finish_squash(1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule